// File: doc/BRIEF.md
# Bridge memory window address decoder

This block keeps the two address windows of a bus bridge: an ordinary memory window and a prefetchable memory window. Each window is a base/limit pair at 1 MB granularity, and the pair is held in one 32-bit configuration word. A small register port writes and reads these words. The writes honour byte enables.

The block decodes two streams of 32-bit addresses. A request that enters from the upstream side is claimed for the downstream bus when its address lands in either window and memory space decoding is enabled. A request that enters from the downstream side is passed upstream when its address misses both windows and bus mastering is enabled. Each stream presents an address with a valid strobe. The decision comes back with its own valid strobe one clock later. The block does not move any data. It only makes the decisions.

Top module: `brwin_decoder`

## Requirements
- R1: After reset, the word at offset 20h (memory window) reads 00000000h and the word at offset 24h (prefetchable window) reads 00010001h.
- R2: In both words the limit field occupies bits 31:20 and the base field occupies bits 15:4, and both fields can be written. In the memory window word, bits 19:16 and 3:0 always read 0 and ignore writes.
- R3: In the prefetchable window word, bits 19:16 and bits 3:0 always read 1h and ignore writes.
- R4: Write byte enable bit i covers data bits 8i+7:8i. A write changes only the writable bits inside enabled bytes and leaves every other bit as it was.
- R5: An address hits a window when its bits 31:20, read as an unsigned number, are at least the base field and strictly below the limit field. A window whose limit is less than or equal to its base matches nothing.
- R6: One clock after `dn_valid` is high, `dn_out_valid` is 1. In that same cycle, `dn_claim` equals `mem_space_en` AND (hit in the memory window OR hit in the prefetchable window), with both sampled with the request.
- R7: One clock after `up_valid` is high, `up_out_valid` is 1. In that same cycle, `up_fwd` equals `bus_master_en` AND the address missing both windows, with both sampled with the request.
- R8: An output valid is 0 in the cycle after its input valid was 0, and the decision output is 0 in that cycle.
- R9: A read at any offset other than 20h and 24h returns 0, and a write to any such offset changes neither window word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Byte offset of the register word |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| mem_space_en | input | 1 | Command bit that enables claiming in the downstream direction |
| bus_master_en | input | 1 | Command bit that enables forwarding in the upstream direction |
| dn_valid | input | 1 | Request from the upstream side is present |
| dn_addr | input | 32 | Address of that request |
| dn_out_valid | output | 1 | Downstream decision is valid |
| dn_claim | output | 1 | Request is claimed for the downstream bus |
| up_valid | input | 1 | Request from the downstream side is present |
| up_addr | input | 32 | Address of that request |
| up_out_valid | output | 1 | Upstream decision is valid |
| up_fwd | output | 1 | Request is forwarded upstream |

## Verification
The bench sweeps all 4096 values of the 1 MB address field against several window layouts. These include the two edges of each window, an empty window, an inverted window, overlapping windows, windows at the top and bottom of the space, and a window covering almost the whole space. A design that made the limit inclusive or the base exclusive would give the wrong decision on exactly one field value per edge. A design that treated an inverted window as a wrapped range would claim large areas it should miss. The command enables change along the sweep, so a decision that ignores its own enable, or takes the other direction's enable, is wrong on many addresses. The register checks use one byte enable at a time and write all-ones over the reserved and indicator nibbles. A design that lets a reserved bit be written or drops a byte enable therefore shows a wrong read-back value.

// File: rtl/brwin_pkg.sv
package brwin_pkg;
  localparam int ADDR_W   = 32;
  localparam int GRAN_LSB = 20;
  localparam int FIELD_W  = ADDR_W - GRAN_LSB;
  localparam int DATA_W   = 32;
  localparam int BE_W     = DATA_W / 8;
  localparam int OFS_W    = 8;
  localparam int NUM_WIN  = 2;
  localparam int LIM_LSB  = 20;
  localparam int BASE_LSB = 4;
  localparam int NIB_W    = 4;
  localparam logic [OFS_W-1:0] WIN0_OFS = 8'h20;
  localparam logic [OFS_W-1:0] WIN_STRIDE = 8'h04;

  typedef logic [FIELD_W-1:0] field_t;

  // Writable bits of a window word: limit and base fields only.
  localparam logic [DATA_W-1:0] WR_MASK =
    {{FIELD_W{1'b1}}, {NIB_W{1'b0}}, {FIELD_W{1'b1}}, {NIB_W{1'b0}}};

  // Half-open range test: base inclusive, limit exclusive.
  function automatic logic in_window(field_t hi, field_t base, field_t lim);
    return (hi >= base) && (hi < lim);
  endfunction

  // Constant nibble shown in the non-field bits of window idx.
  function automatic logic [NIB_W-1:0] ind_nibble(int idx);
    return (idx == 1) ? 4'h1 : 4'h0;
  endfunction

  function automatic logic [DATA_W-1:0] be_mask(logic [BE_W-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < BE_W; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] merge_write(logic [DATA_W-1:0] cur,
                                                    logic [DATA_W-1:0] wd,
                                                    logic [BE_W-1:0] be);
    logic [DATA_W-1:0] m;
    m = be_mask(be) & WR_MASK;
    return (cur & ~m) | (wd & m);
  endfunction
endpackage

// File: rtl/brwin_regs.sv
module brwin_regs
  import brwin_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [OFS_W-1:0]            addr,
  input  logic [BE_W-1:0]             be,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output field_t [NUM_WIN-1:0]        base_o,
  output field_t [NUM_WIN-1:0]        limit_o
);
  logic [NUM_WIN-1:0]             rd_hit;
  logic [NUM_WIN-1:0][DATA_W-1:0] rd_word;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [OFS_W-1:0] MY_OFS = WIN0_OFS + OFS_W'(w) * WIN_STRIDE;
    localparam logic [NIB_W-1:0] IND    = ind_nibble(w);
    field_t base_q, lim_q;
    logic [DATA_W-1:0] cur_word, nxt_word;

    assign cur_word = {lim_q, {NIB_W{1'b0}}, base_q, {NIB_W{1'b0}}};
    assign nxt_word = merge_write(cur_word, wdata, be);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q <= '0;
        lim_q  <= '0;
      end else if (we && addr == MY_OFS) begin
        base_q <= nxt_word[BASE_LSB +: FIELD_W];
        lim_q  <= nxt_word[LIM_LSB +: FIELD_W];
      end
    end

    assign rd_hit[w]  = (addr == MY_OFS);
    assign rd_word[w] = {lim_q, IND, base_q, IND};
    assign base_o[w]  = base_q;
    assign limit_o[w] = lim_q;
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NUM_WIN; w++)
      if (rd_hit[w]) rdata = rdata | rd_word[w];
  end
endmodule

// File: rtl/brwin_match.sv
module brwin_match
  import brwin_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr,
  input  field_t [NUM_WIN-1:0] base_i,
  input  field_t [NUM_WIN-1:0] limit_i,
  output logic                 hit_any
);
  field_t             hi;
  logic [NUM_WIN-1:0] hit_vec;

  assign hi = addr[GRAN_LSB +: FIELD_W];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign hit_vec[w] = in_window(hi, base_i[w], limit_i[w]);
  end

  assign hit_any = |hit_vec;
endmodule

// File: rtl/brwin_dir.sv
module brwin_dir (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic enable,
  input  logic cond,
  output logic out_valid,
  output logic decision
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      decision  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      decision  <= in_valid & enable & cond;
    end
  end
endmodule

// File: rtl/brwin_decoder.sv
module brwin_decoder
  import brwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [OFS_W-1:0]  cfg_addr,
  input  logic [BE_W-1:0]   cfg_be,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              mem_space_en,
  input  logic              bus_master_en,
  input  logic              dn_valid,
  input  logic [ADDR_W-1:0] dn_addr,
  output logic              dn_out_valid,
  output logic              dn_claim,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  output logic              up_out_valid,
  output logic              up_fwd
);
  field_t [NUM_WIN-1:0] win_base;
  field_t [NUM_WIN-1:0] win_limit;
  logic dn_hit;
  logic up_hit;

  brwin_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .be(cfg_be),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .base_o(win_base), .limit_o(win_limit)
  );

  brwin_match u_dn_match (.addr(dn_addr), .base_i(win_base), .limit_i(win_limit), .hit_any(dn_hit));
  brwin_match u_up_match (.addr(up_addr), .base_i(win_base), .limit_i(win_limit), .hit_any(up_hit));

  brwin_dir u_dn_dir (
    .clk(clk), .rst_n(rst_n), .in_valid(dn_valid), .enable(mem_space_en),
    .cond(dn_hit), .out_valid(dn_out_valid), .decision(dn_claim)
  );

  brwin_dir u_up_dir (
    .clk(clk), .rst_n(rst_n), .in_valid(up_valid), .enable(bus_master_en),
    .cond(~up_hit), .out_valid(up_out_valid), .decision(up_fwd)
  );
endmodule

// File: rtl/brwin_decoder_chk.sv
module brwin_decoder_chk
  import brwin_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [OFS_W-1:0]  cfg_addr,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              mem_space_en,
  input logic              bus_master_en,
  input logic              dn_valid,
  input logic              dn_out_valid,
  input logic              dn_claim,
  input logic              dn_hit,
  input logic              up_valid,
  input logic              up_out_valid,
  input logic              up_fwd,
  input logic              up_hit
);
  localparam logic [OFS_W-1:0] PREF_OFS = WIN0_OFS + WIN_STRIDE;

  a_r2_mem_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == WIN0_OFS) |-> (cfg_rdata[19:16] == 4'h0 && cfg_rdata[3:0] == 4'h0));

  a_r3_pref_indicator_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == PREF_OFS) |-> (cfg_rdata[19:16] == 4'h1 && cfg_rdata[3:0] == 4'h1));

  a_r6_claim_needs_hit_and_mse: assert property (@(posedge clk) disable iff (!rst_n)
    dn_claim |-> ($past(dn_valid) && $past(mem_space_en) && $past(dn_hit)));

  a_r7_fwd_needs_miss_and_bme: assert property (@(posedge clk) disable iff (!rst_n)
    up_fwd |-> ($past(up_valid) && $past(bus_master_en) && !$past(up_hit)));

  a_r8_dn_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |=> dn_out_valid);

  a_r8_up_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> up_out_valid);

  a_r8_idle_dn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_valid |=> (!dn_out_valid && !dn_claim));

  a_r8_idle_up_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> (!up_out_valid && !up_fwd));

  a_r9_other_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr != WIN0_OFS && cfg_addr != PREF_OFS) |-> (cfg_rdata == '0));
endmodule

bind brwin_decoder brwin_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .mem_space_en(mem_space_en), .bus_master_en(bus_master_en),
  .dn_valid(dn_valid), .dn_out_valid(dn_out_valid), .dn_claim(dn_claim), .dn_hit(dn_hit),
  .up_valid(up_valid), .up_out_valid(up_out_valid), .up_fwd(up_fwd), .up_hit(up_hit)
);

// File: tb/brwin_decoder_tb_top.sv
module brwin_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_space_en = 1'b0;
  logic        bus_master_en = 1'b0;
  logic        dn_valid = 1'b0;
  logic [31:0] dn_addr = '0;
  logic        dn_out_valid, dn_claim;
  logic        up_valid = 1'b0;
  logic [31:0] up_addr = '0;
  logic        up_out_valid, up_fwd;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  brwin_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_space_en(mem_space_en),
    .bus_master_en(bus_master_en), .dn_valid(dn_valid), .dn_addr(dn_addr),
    .dn_out_valid(dn_out_valid), .dn_claim(dn_claim), .up_valid(up_valid),
    .up_addr(up_addr), .up_out_valid(up_out_valid), .up_fwd(up_fwd)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  function automatic bit inw(int hi, int b, int l);
    return (hi >= b) && (hi < l);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int mb, ml, pb, pl;
    bit pend, exp_dn, exp_up;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd_check("R1 mem reset", 8'h20, 32'h0000_0000);
    rd_check("R1 pref reset", 8'h24, 32'h0001_0001);
    check("R8 dn idle after reset", {30'b0, dn_out_valid, dn_claim}, 0);
    check("R8 up idle after reset", {30'b0, up_out_valid, up_fwd}, 0);

    // R2 / R3 all-ones and all-zeros writes
    wr(8'h20, 4'hF, 32'hFFFF_FFFF);
    rd_check("R2 mem all ones", 8'h20, 32'hFFF0_FFF0);
    wr(8'h24, 4'hF, 32'hFFFF_FFFF);
    rd_check("R3 pref all ones", 8'h24, 32'hFFF1_FFF1);
    wr(8'h24, 4'hF, 32'h0000_0000);
    rd_check("R3 pref zeros", 8'h24, 32'h0001_0001);
    wr(8'h20, 4'hF, 32'h0000_0000);
    rd_check("R2 mem zeros", 8'h20, 32'h0000_0000);

    // R4 one byte lane at a time
    wr(8'h20, 4'h1, 32'hAAAA_AAAA);
    rd_check("R4 be0", 8'h20, 32'h0000_00A0);
    wr(8'h20, 4'h4, 32'hAAAA_AAAA);
    rd_check("R4 be2", 8'h20, 32'h00A0_00A0);
    wr(8'h20, 4'h8, 32'hAAAA_AAAA);
    rd_check("R4 be3", 8'h20, 32'hAAA0_00A0);
    wr(8'h20, 4'h2, 32'hAAAA_AAAA);
    rd_check("R4 be1", 8'h20, 32'hAAA0_AAA0);
    wr(8'h20, 4'h0, 32'h5555_5555);
    rd_check("R4 no lanes", 8'h20, 32'hAAA0_AAA0);
    wr(8'h24, 4'h5, 32'h1234_5678);
    rd_check("R4 pref lanes 0,2", 8'h24, 32'h0031_0071);

    // R9 other offsets
    wr(8'h28, 4'hF, 32'hFFFF_FFFF);
    rd_check("R9 read 28h", 8'h28, 32'h0);
    rd_check("R9 read 1Ch", 8'h1C, 32'h0);
    rd_check("R9 mem untouched", 8'h20, 32'hAAA0_AAA0);
    rd_check("R9 pref untouched", 8'h24, 32'h0031_0071);

    // R5 R6 R7 R8: sweep every 1 MB field value over several layouts
    for (int c = 0; c < 6; c++) begin
      case (c)
        0: begin mb = 'h100; ml = 'h200; pb = 'h300; pl = 'h380; end
        1: begin mb = 'h010; ml = 'h010; pb = 'hFFE; pl = 'hFFF; end
        2: begin mb = 'h500; ml = 'h400; pb = 'h000; pl = 'h001; end
        3: begin mb = 'h000; ml = 'hFFF; pb = 'h800; pl = 'h900; end
        4: begin mb = 'h100; ml = 'h300; pb = 'h200; pl = 'h400; end
        default: begin mb = 'hFFF; ml = 'h000; pb = 'h7FF; pl = 'h800; end
      endcase
      wr(8'h20, 4'hF, {ml[11:0], 4'h0, mb[11:0], 4'h0});
      wr(8'h24, 4'hF, {pl[11:0], 4'h0, pb[11:0], 4'h0});
      pend = 1'b0;
      exp_dn = 1'b0;
      exp_up = 1'b0;
      for (int h = 0; h < 4096; h++) begin
        bit hit, mse, bme;
        @(negedge clk);
        if (pend) begin
          check("R6 dn decision", {30'b0, dn_out_valid, dn_claim}, {30'b0, 1'b1, exp_dn});
          check("R7 up decision", {30'b0, up_out_valid, up_fwd}, {30'b0, 1'b1, exp_up});
        end
        mse = (h % 3) != 0;
        bme = (h % 5) != 0;
        hit = inw(h, mb, ml) || inw(h, pb, pl);   // R5 half-open window test
        exp_dn = mse && hit;
        exp_up = bme && !hit;
        mem_space_en = mse;
        bus_master_en = bme;
        dn_valid = 1'b1;
        up_valid = 1'b1;
        dn_addr = {h[11:0], 20'(h * 7919)};
        up_addr = {h[11:0], 20'(h * 104729)};
        pend = 1'b1;
      end
      @(negedge clk);
      check("R6 dn last", {30'b0, dn_out_valid, dn_claim}, {30'b0, 1'b1, exp_dn});
      check("R7 up last", {30'b0, up_out_valid, up_fwd}, {30'b0, 1'b1, exp_up});
      dn_valid = 1'b0;
      up_valid = 1'b0;
      mem_space_en = 1'b1;
      bus_master_en = 1'b1;
      @(negedge clk);
      check("R8 dn quiet", {30'b0, dn_out_valid, dn_claim}, 0);
      check("R8 up quiet", {30'b0, up_out_valid, up_fwd}, 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule